// File: doc/BRIEF.md
# Serial Control Bus Slave Port

This block is the peripheral end of a four-wire serial control bus: an active-low select, a serial clock, a command data line from the host and a reply data line back to it. All four wires run much slower than the local clock. The block samples them through two-stage synchronizers and finds clock edges in the local clock domain. Bits are taken on each rising serial clock edge, most significant bit first. A byte is handed to local logic the moment its eighth bit arrives. The block does not wait for the select to be released.

Each select window begins with an address/command byte. The block signals that byte with a command strobe, and every later byte in the same window with a data strobe. On the reply line the block shifts out bytes supplied by local logic. It takes a new reply byte at the start of the window and at every byte boundary. The reply enable drops shortly after deselect, so the shared reply line floats. The serial clock may idle either high or low between bytes. The block records the idle level at select time and uses it to decide whether the first falling edge carries meaning.

Top module: `sbus_slave`

## Requirements
- R1: Out of reset, miso_oe, cmd_valid, data_valid and tx_ack are all 0.
- R2: Command data bits are captured on rising serial clock edges, most significant bit first. A completed byte appears on rx_byte in the same cycle as its strobe.
- R3: The first complete byte of a select window raises cmd_valid for one clock. Every later complete byte in that window raises data_valid for one clock. The two strobes are never high together.
- R4: Reception and reply both behave the same whether the serial clock idles low or high while the select is inactive.
- R5: The reply goes out on miso_out most significant bit first. Each bit is stable before the host's rising edge. The reply byte is loaded from tx_data when the window opens and at each later byte boundary. A load with tx_valid at 1 pulses tx_ack for one clock.
- R6: When tx_valid is 0 at a load, the reply byte is all ones (8'hFF) and tx_ack stays 0.
- R7: miso_oe is 1 while selected. It is 0 no later than three clocks after cs_n_in has gone high and stayed high.
- R8: A byte left incomplete when the select is released produces no strobe. The first complete byte of the next window is again a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Bus select, active low |
| sck_in | input | 1 | Bus serial clock |
| mosi_in | input | 1 | Command data from host |
| miso_out | output | 1 | Reply data to host |
| miso_oe | output | 1 | Drive enable for the reply line |
| rx_byte | output | BYTE_W | Most recently completed received byte |
| cmd_valid | output | 1 | Strobe: rx_byte is the command byte |
| data_valid | output | 1 | Strobe: rx_byte is a data byte |
| tx_data | input | BYTE_W | Next reply byte from local logic |
| tx_valid | input | 1 | tx_data holds a reply byte |
| tx_ack | output | 1 | Strobe: tx_data was taken |

## Verification
The bench sweeps both serial clock idle levels against windows of one to four bytes. It runs each window once with reply data supplied and once without. The idle-high runs expose any mishandled leading falling edge, which would shift or repeat a reply byte. The multi-byte runs separate the command strobe from the data strobes. The number of reply loads differs between the two polarities and checks where byte boundaries fall. Windows cut off mid-byte confirm that the partial byte is dropped and that the following window opens with a command byte again.

// File: rtl/sbus_slave.sv
module sbus_slave #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sck_in,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              cmd_valid,
  output logic              data_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ack
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [2:0] cs_q, sck_q;
  logic [1:0] mosi_q;
  logic [CW-1:0] cnt;
  logic first, skip;
  logic [BYTE_W-1:0] rx_sr, tx_sr;

  wire sel   = ~cs_q[1];
  wire start = sel & cs_q[2];
  wire rise  = sel & sck_q[1] & ~sck_q[2];
  wire fall  = sel & ~sck_q[1] & sck_q[2];
  wire [BYTE_W-1:0] rx_next = {rx_sr[BYTE_W-2:0], mosi_q[1]};
  wire [BYTE_W-1:0] tx_next = tx_valid ? tx_data : '1;

  assign miso_out = tx_sr[BYTE_W-1];
  assign miso_oe  = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= '1;
      sck_q      <= '0;
      mosi_q     <= '0;
      cnt        <= '0;
      first      <= 1'b1;
      skip       <= 1'b0;
      rx_sr      <= '0;
      tx_sr      <= '1;
      rx_byte    <= '0;
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      tx_ack     <= 1'b0;
    end else begin
      cs_q       <= {cs_q[1:0], cs_n_in};
      sck_q      <= {sck_q[1:0], sck_in};
      mosi_q     <= {mosi_q[0], mosi_in};
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      tx_ack     <= 1'b0;
      if (!sel) begin
        cnt   <= '0;
        first <= 1'b1;
        skip  <= 1'b0;
      end else begin
        if (start) begin
          tx_sr  <= tx_next;
          tx_ack <= tx_valid;
          skip   <= sck_q[1];
        end else if (fall) begin
          if (skip) begin
            skip <= 1'b0;
          end else if (cnt == '0) begin
            tx_sr  <= tx_next;
            tx_ack <= tx_valid;
          end else begin
            tx_sr <= tx_sr << 1;
          end
        end
        if (rise) begin
          rx_sr <= rx_next;
          if (cnt == LAST) begin
            cnt        <= '0;
            rx_byte    <= rx_next;
            cmd_valid  <= first;
            data_valid <= ~first;
            first      <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

module sbus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_in,
  input logic miso_oe,
  input logic cmd_valid,
  input logic data_valid,
  input logic tx_ack,
  input logic tx_valid
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && data_valid));
  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_data_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  p_cmd_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> miso_oe);
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_ack);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_in && $past(cs_n_in) && $past(cs_n_in, 2) && $past(cs_n_in, 3)) |-> !miso_oe);
  p_ack_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> $past(tx_valid));
endmodule

bind sbus_slave sbus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .miso_oe(miso_oe),
  .cmd_valid(cmd_valid), .data_valid(data_valid), .tx_ack(tx_ack),
  .tx_valid(tx_valid)
);

// File: tb/sbus_slave_bench.sv
module sbus_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, oe, cmd_v, data_v, tx_ack, tx_valid = 1'b0;
  logic [7:0] rx_byte, tx_data;
  int checks = 0, fails = 0, acks = 0, rec_n = 0, trans = 0;
  logic [7:0] rec_b [16];
  logic       rec_c [16];
  bit done = 0;

  always #2.5 clk = ~clk;

  sbus_slave #(.BYTE_W(8)) u_sbus_slave (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sck_in(sck), .mosi_in(mosi),
    .miso_out(miso), .miso_oe(oe), .rx_byte(rx_byte), .cmd_valid(cmd_v),
    .data_valid(data_v), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ack(tx_ack)
  );

  function automatic logic [7:0] pat(int i);
    return 8'hC3 ^ 8'(i * 43);
  endfunction
  function automatic logic [7:0] mk(int t, int k);
    return 8'(8'h3C + t * 29 + k * 89);
  endfunction

  initial tx_data = pat(0);

  always @(negedge clk) if (rst_n) begin
    if ((cmd_v || data_v) && rec_n < 16) begin
      rec_b[rec_n] = rx_byte;
      rec_c[rec_n] = cmd_v;
      rec_n++;
    end
    if (tx_ack) begin
      acks++;
      tx_data = pat(acks);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(bit pol, int nb, int extra, bit vld);
    int base, m, nbits, exp_acks;
    logic [7:0] b, got, exp;
    tx_valid = vld;
    base = acks;
    rec_n = 0;
    sck = pol;
    cs_n = 1'b1;
    wt(8);
    cs_n = 1'b0;
    wt(8);
    m = nb + (extra > 0 ? 1 : 0);
    for (int k = 0; k < m; k++) begin
      b = mk(trans, k);
      nbits = (k < nb) ? 8 : extra;
      got = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
        if (pol) sck = 1'b0;
        mosi = b[i];
        wt(8);
        got = {got[6:0], miso};
        chk(oe === 1'b1, "R7 oe while selected", oe, 1);
        sck = 1'b1;
        wt(8);
        if (!pol) sck = 1'b0;
      end
      if (k < nb) begin
        exp = vld ? pat(base + k) : 8'hFF;
        chk(got === exp, vld ? "R5 R4 reply byte" : "R6 R4 idle reply", got, exp);
      end
    end
    wt(8);
    cs_n = 1'b1;
    wt(4);
    chk(oe === 1'b0, "R7 release after deselect", oe, 0);
    wt(4);
    chk(rec_n == nb, extra > 0 ? "R8 partial byte dropped" : "R3 strobe count", rec_n, nb);
    for (int k = 0; k < nb && k < rec_n; k++) begin
      chk(rec_b[k] === mk(trans, k), "R2 R4 received byte", rec_b[k], mk(trans, k));
      chk(rec_c[k] === (k == 0), k == 0 ? "R3 command strobe" : "R3 data strobe",
          rec_c[k], k == 0);
    end
    exp_acks = vld ? (pol ? m : 1 + nb) : 0;
    chk(acks - base == exp_acks, vld ? "R5 load count" : "R6 no ack", acks - base, exp_acks);
    trans++;
  endtask

  initial begin
    wt(3);
    chk(oe === 1'b0 && cmd_v === 1'b0 && data_v === 1'b0 && tx_ack === 1'b0,
        "R1 reset outputs", {oe, cmd_v, data_v, tx_ack}, 0);
    rst_n = 1'b1;
    wt(4);
    chk(oe === 1'b0, "R1 idle after reset", oe, 0);
    for (int p = 0; p < 2; p++)
      for (int n = 1; n <= 4; n++)
        for (int v = 0; v < 2; v++)
          xfer(p[0], n, 0, v[0]);
    xfer(1'b0, 0, 5, 1'b1);
    xfer(1'b0, 2, 0, 1'b1);
    xfer(1'b1, 1, 3, 1'b1);
    xfer(1'b1, 2, 0, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule